// File: doc/BRIEF.md
# Exposure and Frame Readout Sequencer

This block is the digital control engine of an image-capture path. It stays idle until a start pulse is sampled. It then waits a short arming interval and holds an exposure phase whose length comes from two 8-bit counts: a fine count in small units and a coarse count worth 256 fine units each. After the exposure it walks a serial readout of a `LINES` x `COLS` frame, one pixel per clock. A read-valid level covers the whole readout, and a strobe marks every pixel sample.

When a frame ends, the sequencer generates its own start a fixed number of clocks later, so frames repeat until reset. The exposure counts and the dark-line choice are copied into working registers each time a frame is accepted. The host may therefore rewrite the inputs at any time, and the new values take effect from the next frame. If both counts are zero, the block reads the frame with no exposure phase. An optional dark-reference line can be placed ahead of the image lines. Line index, column index and a dark-line flag come out with each pixel.

Top module: `frame_capture_seq`

## Requirements
- R1: After reset, and while idle, `expose_o`, `read_o`, `strobe_o` and `dark_line_o` are low. The block leaves idle only when `start_i` is sampled high on a rising clock edge.
- R2: If a start is accepted on edge k, the exposure and dark-line inputs present at edge k are captured, and the next phase (exposure or readout) begins at edge k+2.
- R3: `expose_o` stays high for exactly (256*coarse + fine) * `CLK_PER_FINE` consecutive cycles. `read_o` rises on the edge that ends the exposure.
- R4: If coarse and fine are both zero, `expose_o` never rises in that frame and `read_o` rises at edge k+2.
- R5: `read_o` stays high without a break from the first pixel to the last pixel of the frame. Within the frame, consecutive lines are separated by `LINE_GAP` cycles with `strobe_o` low. No gap follows the last line.
- R6: `strobe_o` is high for one cycle per pixel. While it is high, `col_o` runs 0 to `COLS`-1 in ascending order within a line, and `line_o` runs 0 to `LINES`-1 over the image lines.
- R7: If `dark_line_n_i` was low when the frame was accepted, the first line is a dark-reference line of `COLS` samples with `dark_line_o`=1 and `line_o`=0. Image line 0 follows it. Otherwise `dark_line_o` stays 0.
- R8: Five clocks after `read_o` falls, a new start is accepted internally. New inputs are captured at that edge, and the next frame follows R2 to R7.
- R9: Changing the exposure or dark-line inputs while a frame is in progress does not alter that frame.
- R10: A `start_i` pulse while a frame is in progress has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture request, sampled on the rising edge while idle |
| exp_fine_i | input | 8 | Fine exposure count, one unit = `CLK_PER_FINE` clocks |
| exp_coarse_i | input | 8 | Coarse exposure count, one unit = 256 fine units |
| dark_line_n_i | input | 1 | Low: insert a dark-reference line before the image lines |
| expose_o | output | 1 | High during the exposure phase |
| read_o | output | 1 | High for the whole frame readout |
| strobe_o | output | 1 | High for each pixel sample |
| line_o | output | $clog2(LINES) | Image line index of the current sample (0 on the dark line) |
| col_o | output | $clog2(COLS) | Column index of the current sample |
| dark_line_o | output | 1 | High on samples of the dark-reference line |

## Verification
A wrong arming or restart count moves the whole frame by whole cycles. That shift shows at the ports on the first edge where `expose_o` or `read_o` should change, and it carries into every later frame. A fault in the prescaler or in the exposure unit counter changes how long `expose_o` stays high, and this appears at the end of the first exposure. It is most visible with a coarse count, where one lost unit costs 256 fine steps. A corrupt column, line or dark-phase register gives a wrong index or flag on the very next strobe, or `read_o` falls early or late at the frame boundary. The bench computes every expected waveform from the cycle count since the accepting edge, so any one-cycle slip is caught.

// File: rtl/cap_seq_pkg.sv
`timescale 1ns/1ps
package cap_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ARM     = 3'd1,
      ST_EXPOSE  = 3'd2,
      ST_READ    = 3'd3,
      ST_RESTART = 3'd4
   } seq_state_e;

   // width of a counter that must hold values 0 .. n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cap_seq_exp_timer.sv
`timescale 1ns/1ps
module cap_seq_exp_timer
   import cap_seq_pkg::*;
#(
   parameter int unsigned CLK_PER_FINE = 8,
   parameter int unsigned UNIT_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [UNIT_W-1:0] units_i,
   input  logic              run_i,
   output logic              last_o
);

   localparam logic [UNIT_W-1:0] UNIT_ONE = UNIT_W'(1);

   logic [UNIT_W-1:0] units_q;
   logic              tick;

   initial begin
      if (CLK_PER_FINE < 1 || UNIT_W < 1)
         $error("cap_seq_exp_timer: bad parameters");
   end

   generate
      if (CLK_PER_FINE > 1) begin : g_prescale
         localparam int unsigned PW = cnt_width(CLK_PER_FINE);
         localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_FINE - 1);
         localparam logic [PW-1:0] PRE_ONE  = PW'(1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (load_i) begin
               pre_q <= '0;
            end else if (run_i) begin
               pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_ONE;
            end
         end

         assign tick = (pre_q == PRE_LAST);
      end else begin : g_direct
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         units_q <= '0;
      end else if (load_i) begin
         units_q <= units_i;
      end else if (run_i && tick && units_q != '0) begin
         units_q <= units_q - UNIT_ONE;
      end
   end

   assign last_o = run_i && tick && (units_q == UNIT_ONE);

   // R3: the controller never runs an exposure with an empty unit count
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (units_q != '0));

endmodule

// File: rtl/cap_seq_scan.sv
`timescale 1ns/1ps
module cap_seq_scan
   import cap_seq_pkg::*;
#(
   parameter int unsigned LINES    = 128,
   parameter int unsigned COLS     = 128,
   parameter int unsigned LINE_GAP = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic                       run_i,
   input  logic                       dark_en_i,
   output logic                       strobe_o,
   output logic [$clog2(COLS)-1:0]    col_o,
   output logic [$clog2(LINES)-1:0]   line_o,
   output logic                       dark_o,
   output logic                       done_o
);

   localparam int unsigned CW = $clog2(COLS);
   localparam int unsigned LW = $clog2(LINES);
   localparam logic [CW-1:0] COL_LAST  = CW'(COLS - 1);
   localparam logic [CW-1:0] COL_ONE   = CW'(1);
   localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);
   localparam logic [LW-1:0] LINE_ONE  = LW'(1);

   logic [CW-1:0] col_q;
   logic [LW-1:0] line_q;
   logic          dark_phase_q;
   logic          in_gap;
   logic          pix;
   logic          line_end;

   initial begin
      if (LINES < 2 || COLS < 2)
         $error("cap_seq_scan: LINES and COLS must be at least 2");
   end

   assign pix      = run_i && !in_gap;
   assign line_end = pix && (col_q == COL_LAST);
   assign done_o   = line_end && !dark_phase_q && (line_q == LINE_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q        <= '0;
         line_q       <= '0;
         dark_phase_q <= 1'b0;
      end else if (load_i) begin
         col_q        <= '0;
         line_q       <= '0;
         dark_phase_q <= dark_en_i;
      end else if (pix) begin
         col_q <= (col_q == COL_LAST) ? '0 : col_q + COL_ONE;
         if (line_end && !done_o) begin
            if (dark_phase_q) begin
               dark_phase_q <= 1'b0;
            end else begin
               line_q <= line_q + LINE_ONE;
            end
         end
      end
   end

   generate
      if (LINE_GAP > 0) begin : g_gap
         localparam int unsigned GW = cnt_width(LINE_GAP);
         localparam logic [GW-1:0] GAP_LAST = GW'(LINE_GAP - 1);
         localparam logic [GW-1:0] GAP_ONE  = GW'(1);
         logic [GW-1:0] gap_q;
         logic          gap_q_act;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gap_q     <= '0;
               gap_q_act <= 1'b0;
            end else if (load_i) begin
               gap_q     <= '0;
               gap_q_act <= 1'b0;
            end else if (line_end && !done_o) begin
               gap_q     <= '0;
               gap_q_act <= 1'b1;
            end else if (run_i && gap_q_act) begin
               if (gap_q == GAP_LAST) begin
                  gap_q_act <= 1'b0;
               end else begin
                  gap_q <= gap_q + GAP_ONE;
               end
            end
         end

         assign in_gap = gap_q_act;
      end else begin : g_nogap
         assign in_gap = 1'b0;
      end
   endgenerate

   assign strobe_o = pix;
   assign col_o    = col_q;
   assign line_o   = line_q;
   assign dark_o   = pix && dark_phase_q;

   // R6: inside a line each sample advances the column by one
   p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && col_q != '0) |-> (col_q == $past(col_q) + COL_ONE));

   // R5: the final pixel of a frame is followed by no further sample
   p_last_pixel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !strobe_o);

endmodule

// File: rtl/cap_seq_ctrl.sv
`timescale 1ns/1ps
module cap_seq_ctrl
   import cap_seq_pkg::*;
#(
   parameter int unsigned START_LAT   = 2,
   parameter int unsigned RESTART_GAP = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       zero_exp_i,
   input  logic       exp_last_i,
   input  logic       scan_done_i,
   output seq_state_e state_o,
   output logic       accept_o,
   output logic       timer_load_o,
   output logic       scan_load_o
);

   localparam int unsigned CNT_MAX = (START_LAT > RESTART_GAP) ? START_LAT : RESTART_GAP;
   localparam int unsigned CNT_W   = cnt_width(CNT_MAX);
   localparam logic [CNT_W-1:0] ARM_INIT  = CNT_W'(START_LAT - 1);
   localparam logic [CNT_W-1:0] GAP_INIT  = CNT_W'(RESTART_GAP - 1);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   seq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             arm_done;

   initial begin
      if (START_LAT < 1 || RESTART_GAP < 1)
         $error("cap_seq_ctrl: latencies must be at least 1");
   end

   assign arm_done     = (state_q == ST_ARM) && (cnt_q == '0);
   assign accept_o     = ((state_q == ST_IDLE) && start_i) ||
                         ((state_q == ST_RESTART) && (cnt_q == '0));
   assign timer_load_o = arm_done && !zero_exp_i;
   assign scan_load_o  = (arm_done && zero_exp_i) ||
                         ((state_q == ST_EXPOSE) && exp_last_i);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_ARM;
               cnt_d   = ARM_INIT;
            end
         end
         ST_ARM: begin
            if (cnt_q != '0) begin
               cnt_d = cnt_q - CNT_ONE;
            end else begin
               state_d = zero_exp_i ? ST_READ : ST_EXPOSE;
            end
         end
         ST_EXPOSE: begin
            if (exp_last_i) state_d = ST_READ;
         end
         ST_READ: begin
            if (scan_done_i) begin
               state_d = ST_RESTART;
               cnt_d   = GAP_INIT;
            end
         end
         ST_RESTART: begin
            if (cnt_q != '0) begin
               cnt_d = cnt_q - CNT_ONE;
            end else begin
               state_d = ST_ARM;
               cnt_d   = ARM_INIT;
            end
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign state_o = state_q;

   // R2: a sampled start in idle always moves to arming
   p_start_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && start_i) |=> (state_q == ST_ARM));

   // R8: the end of a readout always enters the restart wait
   p_restart_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_READ) && scan_done_i) |=> (state_q == ST_RESTART));

endmodule

// File: rtl/frame_capture_seq.sv
`timescale 1ns/1ps
module frame_capture_seq
   import cap_seq_pkg::*;
#(
   parameter int unsigned LINES        = 128,
   parameter int unsigned COLS         = 128,
   parameter int unsigned CLK_PER_FINE = 8,
   parameter int unsigned LINE_GAP     = 0,
   parameter int unsigned START_LAT    = 2,
   parameter int unsigned RESTART_GAP  = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [7:0]               exp_fine_i,
   input  logic [7:0]               exp_coarse_i,
   input  logic                     dark_line_n_i,
   output logic                     expose_o,
   output logic                     read_o,
   output logic                     strobe_o,
   output logic [$clog2(LINES)-1:0] line_o,
   output logic [$clog2(COLS)-1:0]  col_o,
   output logic                     dark_line_o
);

   localparam int unsigned UNIT_W = 16;

   seq_state_e        state;
   logic              accept;
   logic              timer_load;
   logic              scan_load;
   logic              exp_last;
   logic              scan_done;
   logic [7:0]        fine_q;
   logic [7:0]        coarse_q;
   logic              dark_n_q;
   logic [UNIT_W-1:0] exp_units;
   logic              zero_exp;

   initial begin
      if (LINES < 2 || COLS < 2 || CLK_PER_FINE < 1)
         $error("frame_capture_seq: bad geometry or prescale");
   end

   // working copies, refreshed only when a frame is accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fine_q   <= '0;
         coarse_q <= '0;
         dark_n_q <= 1'b1;
      end else if (accept) begin
         fine_q   <= exp_fine_i;
         coarse_q <= exp_coarse_i;
         dark_n_q <= dark_line_n_i;
      end
   end

   // one coarse unit weighs 256 fine units
   assign exp_units = {coarse_q, fine_q};
   assign zero_exp  = (exp_units == '0);

   cap_seq_ctrl #(
      .START_LAT   (START_LAT),
      .RESTART_GAP (RESTART_GAP)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .zero_exp_i   (zero_exp),
      .exp_last_i   (exp_last),
      .scan_done_i  (scan_done),
      .state_o      (state),
      .accept_o     (accept),
      .timer_load_o (timer_load),
      .scan_load_o  (scan_load)
   );

   cap_seq_exp_timer #(
      .CLK_PER_FINE (CLK_PER_FINE),
      .UNIT_W       (UNIT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (timer_load),
      .units_i (exp_units),
      .run_i   (state == ST_EXPOSE),
      .last_o  (exp_last)
   );

   cap_seq_scan #(
      .LINES    (LINES),
      .COLS     (COLS),
      .LINE_GAP (LINE_GAP)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (scan_load),
      .run_i     (state == ST_READ),
      .dark_en_i (!dark_n_q),
      .strobe_o  (strobe_o),
      .col_o     (col_o),
      .line_o    (line_o),
      .dark_o    (dark_line_o),
      .done_o    (scan_done)
   );

   assign expose_o = (state == ST_EXPOSE);
   assign read_o   = (state == ST_READ);

   // R5: pixel samples appear only inside the read window
   p_strobe_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> read_o);

   // R7: with the dark line selected the readout opens on it
   p_dark_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(read_o) && !dark_n_q) |-> dark_line_o);

   // R4: an exposure phase never runs on a zero count
   p_expose_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expose_o |-> (exp_units != '0));

endmodule

// File: tb/frame_capture_seq_tb.sv
`timescale 1ns/1ps
module frame_capture_seq_tb;

   localparam int LINES = 3;
   localparam int COLS  = 4;
   localparam int CPF   = 2;
   localparam int GAP   = 1;
   localparam int SLAT  = 2;
   localparam int RGAP  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] fine = 8'd0;
   logic [7:0] coarse = 8'd0;
   logic       dark_n = 1'b1;
   logic       expose_o, read_o, strobe_o, dark_line_o;
   logic [$clog2(LINES)-1:0] line_o;
   logic [$clog2(COLS)-1:0]  col_o;

   frame_capture_seq #(
      .LINES (LINES), .COLS (COLS), .CLK_PER_FINE (CPF),
      .LINE_GAP (GAP), .START_LAT (SLAT), .RESTART_GAP (RGAP)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i),
      .exp_fine_i (fine), .exp_coarse_i (coarse), .dark_line_n_i (dark_n),
      .expose_o (expose_o), .read_o (read_o), .strobe_o (strobe_o),
      .line_o (line_o), .col_o (col_o), .dark_line_o (dark_line_o)
   );

   always #4 clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   string scen   = "R1 reset";
   bit    done_f = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, scen, act, exp, $time);
      end
   endtask

   // input snapshots at the design's sampling edge
   logic       start_s = 1'b0;
   logic [7:0] fine_s = 8'd0, coarse_s = 8'd0;
   logic       dark_n_s = 1'b1;
   always @(posedge clk) begin
      start_s  <= start_i;
      fine_s   <= fine;
      coarse_s <= coarse;
      dark_n_s <= dark_n;
   end

   // arithmetic frame model: t = edges since the accepting edge
   bit act_f = 1'b0;
   int t = 0, U = 0, d = 0, E = 0, F = 0, fno = 0;

   task automatic latch_cfg();
      int l;
      U = int'(coarse_s) * 256 + int'(fine_s);
      d = dark_n_s ? 0 : 1;
      E = U * CPF;
      l = LINES + d;
      F = l * COLS + (l - 1) * GAP;
   endtask

   always @(negedge clk) begin
      if (!done_f) begin
         if (!rst_n) begin
            act_f = 1'b0;
            chk(expose_o == 1'b0, "R1", int'(expose_o), 0);
            chk(read_o == 1'b0, "R1", int'(read_o), 0);
            chk(strobe_o == 1'b0, "R1", int'(strobe_o), 0);
         end else begin
            if (act_f) begin
               t++;
               if (t == SLAT + E + F + RGAP) begin
                  latch_cfg();
                  fno++;
                  t = 0;
               end
            end else if (start_s) begin
               act_f = 1'b1;
               t = 0;
               fno = 0;
               latch_cfg();
            end
            if (!act_f) begin
               chk(expose_o == 1'b0, "R1", int'(expose_o), 0);
               chk(read_o == 1'b0, "R1", int'(read_o), 0);
               chk(strobe_o == 1'b0, "R1", int'(strobe_o), 0);
               chk(dark_line_o == 1'b0, "R1", int'(dark_line_o), 0);
            end else begin
               bit    ee, er, es, ed;
               int    p, li, ci, el;
               string te, tr;
               ee = (t >= SLAT) && (t < SLAT + E);
               er = (t >= SLAT + E) && (t < SLAT + E + F);
               p  = t - SLAT - E;
               li = (p >= 0) ? p / (COLS + GAP) : 0;
               ci = (p >= 0) ? p % (COLS + GAP) : 0;
               es = er && (ci < COLS);
               ed = es && (d == 1) && (li == 0);
               el = (d == 1 && li > 0) ? li - 1 : li;
               if (U == 0)          te = "R4";
               else if (t <= SLAT)  te = (fno > 0) ? "R8" : "R2";
               else                 te = "R3";
               if (fno > 0 && t <= SLAT + E)  tr = "R8";
               else if (U == 0 && t <= SLAT)  tr = "R4";
               else                           tr = "R5";
               chk(expose_o == ee, te, int'(expose_o), int'(ee));
               chk(read_o == er, tr, int'(read_o), int'(er));
               chk(strobe_o == es, "R6", int'(strobe_o), int'(es));
               chk(dark_line_o == ed, "R7", int'(dark_line_o), int'(ed));
               if (es && strobe_o) begin
                  chk(int'(col_o) == ci, "R6", int'(col_o), ci);
                  chk(int'(line_o) == el, (ed ? "R7" : "R6"), int'(line_o), el);
               end
            end
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      wait_cyc(1);
      start_i = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      done_f = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      scen = "R1 idle without start";
      wait_cyc(10);

      scen = "R2 R3 R9 R10 settings rewritten and start repeated mid-frame";
      fine = 8'd3; coarse = 8'd0; dark_n = 1'b1;
      wait_cyc(1);
      pulse_start();
      wait_cyc(11);
      fine = 8'd1; dark_n = 1'b0;
      wait_cyc(3);
      pulse_start();
      wait_cyc(80);

      scen = "R1 reset during frame";
      do_reset();
      wait_cyc(6);

      scen = "R4 R7 R8 zero exposure with dark line";
      fine = 8'd0; coarse = 8'd0; dark_n = 1'b0;
      wait_cyc(1);
      pulse_start();
      wait_cyc(70);

      do_reset();
      scen = "R3 R8 coarse weighting";
      fine = 8'd2; coarse = 8'd1; dark_n = 1'b1;
      wait_cyc(1);
      pulse_start();
      wait_cyc(1100);

      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      #3;
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      finish_run();
   end

endmodule